// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a register-mapped SPI master. Software loads outgoing bytes into a 16-entry transmit queue through a shared data port and collects incoming bytes from a 16-entry receive queue through the same port. A single control/status word sets the SPI mode, picks one of three chip-select lines and their active levels, arms the transfer, and enables two interrupt causes. A third register sets the serial clock divider.

While the transfer-active bit is set, the shifter takes bytes from the transmit queue one at a time and sends them MSB first on `sclk`/`mosi`. It samples `miso` into the receive queue. The selected chip select is held asserted for the whole time the transfer is armed. The interrupt scheme is built for refilling the queues. A "needs reading" flag rises when 12 receive entries are occupied, which leaves four byte-times of slack. A "done" flag rises when the transmit side has run dry. Software then drains the rest of the receive queue one byte at a time using the "data present" flag.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control word reads as zero and the status flags show only transmit-space (bit 18) set, so the word at offset 0x00 reads 0x0004_0000. All three chip selects sit high (active-low by default), `sclk` is low and `irq` is low.
- R2: Offset 0x00 (word index `reg_addr[3:2]`=0) holds these fields, each read back as written:
  - bits [1:0]: chip-select index
  - bit 2: CPHA
  - bit 3: CPOL
  - bit 6: global active-high select
  - bit 7: transfer active
  - bit 9: done-interrupt enable
  - bit 10: needs-reading-interrupt enable
  - bits 23:21: per-line active-high select

  Status bits 20:16 are read-only, and writes to them have no effect.
- R3: Writes to the data port (offset 0x04) fill a 16-byte transmit queue. A write to a full queue is dropped. Status bit 18 is 1 while fewer than 16 bytes are queued.
- R4: A read of offset 0x04 returns the oldest received byte and removes it. A read with the receive queue empty returns 0 and changes nothing. Status bit 17 is 1 while at least one byte is held.
- R5: Status bit 19 is 1 while 12 or more bytes are received and waiting. Status bit 20 is 1 when all 16 entries are full.
- R6: Status bit 16 (done) is 1 when transfer-active is set, the transmit queue is empty and no byte is being shifted. This includes the cycle right after the transfer is armed with an empty queue.
- R7: `irq` is high when the done flag and the done-interrupt enable are both set, or when the needs-reading flag and its enable are both set.
- R8: Writing 1 to control bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue. Both bits always read as 0.
- R9: Offset 0x08 holds a 16-bit divider D. For even D of 2 or more, one `sclk` period lasts D system clocks. D=1 acts as 2. D=0 gives the slowest rate, a period of 65536 clocks.
- R10: CPOL sets the idle level of `sclk`. With CPHA=0, data is sampled on the leading edge and `mosi` changes on the trailing edge. With CPHA=1, `mosi` changes on the leading edge and data is sampled on the trailing edge. Bytes go out MSB first.
- R11: While transfer-active is set, chip-select line k (k=0..2) matching the index is driven to its active level. The active level is high if bit 6 or bit 21+k is set, otherwise low. Every other line rests at its inactive level. Index 3 selects no line.
- R12: No new byte starts while the receive queue is full, and `sclk` stays at its idle level until an entry is read.
- R13: Clearing transfer-active abandons any byte in flight without storing it. `sclk` returns to idle and all chip selects go inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive queue at 0x04) |
| reg_addr | input | 4 | Byte offset; bits [3:2] pick the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select lines |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a single register access per cycle, so a write and a read never arrive together. They also assume the divider and the mode bits are not rewritten while a byte is in flight. The stimulus sets the divider and mode with transfer-active clear, arms the transfer in a separate write, and only touches the configuration again after done is seen or when deliberately aborting. `miso` is looped back inverted from `mosi`, which makes every received byte a known function of the sent one whatever the phase.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH     = 16,
  parameter int RXR_LEVEL = 12,
  parameter int DIVW      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [2:0]  spi_cs,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] NEED = CW'(RXR_LEVEL);

  logic [1:0]      csel;
  logic            cpha, cpol, pol_all, ta, intd, intr;
  logic [2:0]      pol_line;
  logic [DIVW-1:0] div;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic            busy, phase;
  logic [3:0]      ecnt;
  logic [DIVW-1:0] hcnt, half;
  logic [7:0]      tx_sr, rx_sr;

  wire wr_ctrl = reg_wr && reg_addr[3:2] == 2'd0;
  wire wr_data = reg_wr && reg_addr[3:2] == 2'd1;
  wire wr_div  = reg_wr && reg_addr[3:2] == 2'd2;
  wire rd_data = reg_rd && reg_addr[3:2] == 2'd1;
  wire clr_tx  = wr_ctrl && reg_wdata[4];
  wire clr_rx  = wr_ctrl && reg_wdata[5];

  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == FULL;
  wire done     = ta && tx_empty && !busy;
  wire rxr      = rx_cnt >= NEED;

  wire start    = ta && !busy && !tx_empty && !rx_full;
  wire edge_now = busy && hcnt == '0;
  wire lead     = ~ecnt[0];
  wire sample   = edge_now && (lead ^ cpha);
  wire shift_o  = edge_now && !(lead ^ cpha) && (cpha ? ecnt != 4'd0 : ecnt != 4'd15);
  wire last     = edge_now && ecnt == 4'd15;
  wire [7:0] rx_next = {rx_sr[6:0], miso};
  wire [7:0] rx_byte = sample ? rx_next : rx_sr;

  wire tx_push = wr_data && tx_cnt != FULL;
  wire tx_pop  = start;
  wire rx_push = last;
  wire rx_pop  = rd_data && rx_cnt != '0;

  always_comb begin
    if (div == '0)                   half = {1'b1, {(DIVW-1){1'b0}}};
    else if (div[DIVW-1:1] == '0)    half = DIVW'(1);
    else                             half = {1'b0, div[DIVW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {csel, cpha, cpol, pol_all, ta, intd, intr, pol_line} <= '0;
      div <= '0;
    end else begin
      if (wr_ctrl) begin
        csel     <= reg_wdata[1:0];
        cpha     <= reg_wdata[2];
        cpol     <= reg_wdata[3];
        pol_all  <= reg_wdata[6];
        ta       <= reg_wdata[7];
        intd     <= reg_wdata[9];
        intr     <= reg_wdata[10];
        pol_line <= reg_wdata[23:21];
      end
      if (wr_div) div <= reg_wdata[DIVW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (clr_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (clr_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; ecnt <= '0; hcnt <= '0;
      tx_sr <= '0; rx_sr <= '0;
    end else if (!ta) begin
      busy  <= 1'b0;
      phase <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= 1'b0;
      ecnt  <= '0;
      hcnt  <= half - 1'b1;
      tx_sr <= tx_mem[tx_rp];
    end else if (edge_now) begin
      phase <= last ? 1'b0 : ~phase;
      hcnt  <= half - 1'b1;
      ecnt  <= ecnt + 1'b1;
      if (sample)  rx_sr <= rx_next;
      if (shift_o) tx_sr <= {tx_sr[6:0], 1'b0};
      if (last)    busy  <= 1'b0;
    end else if (busy) begin
      hcnt <= hcnt - 1'b1;
    end
  end

  assign sclk = cpol ^ phase;
  assign mosi = tx_sr[7];
  assign irq  = (intd && done) || (intr && rxr);

  logic [2:0] act_lvl;
  for (genvar k = 0; k < 3; k++) begin : g_cs
    assign act_lvl[k] = pol_all | pol_line[k];
    assign spi_cs[k]  = (ta && csel == 2'(k)) ? act_lvl[k] : ~act_lvl[k];
  end

  wire [31:0] ctrl_word = {8'd0, pol_line, rx_full, rxr, tx_cnt != FULL, rx_cnt != '0, done,
                           5'd0, intr, intd, 1'b0, ta, pol_all, 2'b00, cpol, cpha, csel};

  always_comb begin
    case (reg_addr[3:2])
      2'd0:    reg_rdata = ctrl_word;
      2'd1:    reg_rdata = (rx_cnt != '0) ? {24'd0, rx_mem[rx_rp]} : 32'd0;
      2'd2:    reg_rdata = {{(32-DIVW){1'b0}}, div};
      default: reg_rdata = 32'd0;
    endcase
  end

  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL); // R3
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL); // R5
  AST_CLEAR_TX_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr_tx |=> tx_empty); // R8
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_cnt == '0) |=> $stable(rx_rp)); // R4
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk == cpol); // R10
  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !busy) |=> !busy); // R12
  AST_TA_LOW_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) !ta |-> spi_cs == ~act_lvl); // R13
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (intd && done) |-> irq); // R7
endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sclk, mosi, miso;
  logic [2:0] spi_cs;
  logic irq;

  always #2 clk = ~clk;
  assign miso = ~mosi;

  spi_fifo_master dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .spi_cs(spi_cs), .irq(irq));

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic cur_cpol = 1'b0, cur_cpha = 1'b0;
  logic [7:0] mon_sr = '0;
  int mon_tog = 0, tcyc_last = 0, tcyc_prev = 0;
  always @(sclk) begin
    mon_tog   = mon_tog + 1;
    tcyc_prev = tcyc_last;
    tcyc_last = cyc;
    if (sclk == (cur_cpol == cur_cpha)) mon_sr = {mon_sr[6:0], mosi};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int n = 0; n < 5000; n++) begin
      rd(4'h0, s);
      if (s[16]) return;
    end
    chk("R6 done timeout", 32'd0, 32'd1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    @(posedge clk);
    while (cyc < 190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  // {mode[1:0] (cpol,cpha), divider, tx byte, expected sclk period}
  localparam logic [41:0] VEC [6] = '{
    {2'd0, 16'd2,  8'hA5, 16'd2},
    {2'd1, 16'd4,  8'h3C, 16'd4},
    {2'd2, 16'd8,  8'h81, 16'd8},
    {2'd3, 16'd1,  8'h5E, 16'd2},
    {2'd0, 16'd16, 8'hF0, 16'd16},
    {2'd3, 16'd4,  8'h0F, 16'd4}
  };

  initial begin
    logic [31:0] s, d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, s);
    chk("R1 status", s, 32'h0004_0000);
    chk("R1 cs", {29'd0, spi_cs}, 32'd7);
    chk("R1 sclk/irq", {30'd0, sclk, irq}, 32'd0);

    // R10 R9 table walk: modes, dividers, loopback
    foreach (VEC[i]) begin
      logic [1:0] m = VEC[i][41:40];
      logic [15:0] dv = VEC[i][39:24];
      logic [7:0] tb = VEC[i][23:16];
      logic [15:0] per = VEC[i][15:0];
      cur_cpol = m[1]; cur_cpha = m[0];
      wr(4'h8, {16'd0, dv});
      wr(4'h4, {24'd0, tb});
      wr(4'h0, 32'h80 | {28'd0, m, 2'b00});
      wait_done();
      chk("R10 mosi byte", {24'd0, mon_sr}, {24'd0, tb});
      chk("R9 sclk period", 32'(2 * (tcyc_last - tcyc_prev)), {16'd0, per});
      chk("R10 idle level", {31'd0, sclk}, {31'd0, m[1]});
      rd(4'h4, d);
      chk("R4 rx byte", d, {24'd0, ~tb});
      wr(4'h0, 32'h0);
    end
    cur_cpol = 1'b0; cur_cpha = 1'b0;

    // R2 control layout and read-only status
    wr(4'h0, 32'h00FF_064F);
    rd(4'h0, s);
    chk("R2 readback", s, 32'h00E4_064F);
    wr(4'h0, 32'h0);

    // R3 fill TX with TA off, 17th write dropped
    for (int i = 0; i < 16; i++) wr(4'h4, 32'(i * 17));
    wr(4'h4, 32'hEE);
    rd(4'h0, s);
    chk("R3 TXD clear when full", {31'd0, s[18]}, 32'd0);

    // R8 clear TX
    wr(4'h0, 32'h10);
    rd(4'h0, s);
    chk("R8 clear tx", s, 32'h0004_0000);

    // R5 R7 fill RX through a burst
    for (int i = 0; i < 16; i++) wr(4'h4, 32'(i * 17));
    wr(4'h4, 32'hEE);
    wr(4'h8, 32'd2);
    wr(4'h0, 32'h480);
    wait_done();
    rd(4'h0, s);
    chk("R5 full status", s, 32'h001F_0480);
    chk("R7 irq on rxr", {31'd0, irq}, 32'd1);

    // R12 stall while RX full
    wr(4'h4, 32'h77);
    repeat (40) @(negedge clk);
    rd(4'h0, s);
    chk("R12 stalled not done", {31'd0, s[16]}, 32'd0);
    chk("R12 sclk idle", {31'd0, sclk}, 32'd0);
    rd(4'h4, d);
    chk("R4 first byte", d, 32'h0000_00FF);
    wait_done();

    // R4 R5 drain: 15 remaining burst bytes then the stalled byte
    for (int i = 1; i <= 16; i++) begin
      if (i == 5) begin
        rd(4'h0, s);
        chk("R5 rxr at 12", {31'd0, s[19]}, 32'd1);
      end
      if (i == 6) begin
        rd(4'h0, s);
        chk("R5 rxr at 11", {31'd0, s[19]}, 32'd0);
      end
      rd(4'h4, d);
      chk("R4 order", d, (i == 16) ? 32'h88 : {24'd0, ~8'(i * 17)});
    end
    rd(4'h4, d);
    chk("R4 empty read", d, 32'd0);
    rd(4'h4, d);
    rd(4'h0, s);
    chk("R4 empty stays", {d[7:0], 7'd0, s[17]}, 16'd0);
    chk("R3 dropped byte never sent", {31'd0, s[16]}, 32'd1);

    // R6 R7 done and its interrupt
    wr(4'h0, 32'h0);
    wr(4'h0, 32'h80);
    rd(4'h0, s);
    chk("R6 done on arm", {31'd0, s[16]}, 32'd1);
    wr(4'h0, 32'h280);
    chk("R7 irq on done", {31'd0, irq}, 32'd1);
    wr(4'h0, 32'h200);
    chk("R7 no irq without TA", {31'd0, irq}, 32'd0);

    // R11 chip selects
    wr(4'h0, 32'h81);
    chk("R11 cs1 low-active", {29'd0, spi_cs}, 32'd5);
    wr(4'h0, 32'hC1);
    chk("R11 global high", {29'd0, spi_cs}, 32'd2);
    wr(4'h0, 32'hC3);
    chk("R11 index 3 none", {29'd0, spi_cs}, 32'd0);
    wr(4'h0, 32'h0080_0080);
    chk("R11 per-line pol", {29'd0, spi_cs}, 32'd2);
    wr(4'h0, 32'h01);
    chk("R11 TA off", {29'd0, spi_cs}, 32'd7);

    // R9 R13 slowest divider then abort
    wr(4'h8, 32'd0);
    wr(4'h4, 32'h55);
    wr(4'h0, 32'h80);
    base = mon_tog;
    for (int n = 0; n < 70000 && mon_tog < base + 2; n++) @(negedge clk);
    chk("R9 divider zero half", 32'(tcyc_last - tcyc_prev), 32'd32768);
    wr(4'h0, 32'h0);
    chk("R13 sclk idle", {31'd0, sclk}, 32'd0);
    chk("R13 cs inactive", {29'd0, spi_cs}, 32'd7);
    rd(4'h4, d);
    chk("R13 byte discarded", d, 32'd0);

    finish_run();
  end
endmodule